// File: doc/BRIEF.md
# I2C Address-Phase Clock Stretcher

This block sits beside an I2C byte receiver and gives software, or an address comparator, time to look at the first byte after a start condition before the acknowledge bit goes out. It samples SDA on each SCL rising edge, most significant bit first, and shows the first byte on a data output with a one-cycle valid strobe. It then pulls SCL low at the falling edge that opens the ninth clock. An open-drain remote master sees a low clock and waits.

The hold lasts until the enable input is cleared. When it is cleared, the block first puts the acknowledge level on its SDA drive, as chosen by the decision input: low for an acknowledge, released for a not-acknowledge. After a fixed setup time it lets SCL go. That SDA drive is removed at the falling edge that ends the ninth clock. Later bytes in the same transfer pass through untouched until the next start.

An early-capture variant strobes the data one falling edge sooner, after only seven bits. The seven address bits then sit right-aligned with a zero on top.

Top module: `i2c_addr_hold`

## Requirements
- R1: While reset is asserted and just after it is released, rx_valid, scl_drive_low and sda_drive_low are all 0.
- R2: In the default variant, rx_valid comes one time per start, after the eighth SCL rising edge. At that time rx_data holds the eight SDA samples taken on those rising edges, with the first sample in bit 7.
- R3: rx_valid is a single-cycle pulse. It fires only for the first byte after start_det; a second byte in the same transfer produces no pulse.
- R4: With EARLY_CAPTURE=1, rx_valid fires at the SCL falling edge after the seventh rising edge. rx_data then equals {1'b0, first seven samples}, so it is the full byte shifted right by one.
- R5: With hold_en=1 at the SCL falling edge that follows the eighth rising edge, scl_drive_low becomes 1.
- R6: scl_drive_low stays 1, and the SCL line stays low, for as long as hold_en remains 1.
- R7: After hold_en is cleared, sda_drive_low takes the value of ack_en (1 = acknowledge) while scl_drive_low is still 1. SCL is released ACK_SETUP cycles later, with the SDA drive unchanged at that moment.
- R8: With hold_en=0 at the ninth-clock falling edge, SCL is never held. sda_drive_low takes ack_en at that falling edge.
- R9: sda_drive_low returns to 0 at the SCL falling edge that ends the ninth clock. Neither drive asserts again before the next start_det.
- R10: A start_det in the middle of a byte clears the bit count, and the byte that follows is received whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sample of the SCL line |
| sda_in | input | 1 | Sample of the SDA line |
| start_det | input | 1 | One-cycle pulse from the start-condition detector |
| hold_en | input | 1 | 1 = stretch SCL at the ninth clock; clear it to release |
| ack_en | input | 1 | Acknowledge decision: 1 = drive SDA low in the ninth clock |
| rx_data | output | DATA_W | Captured first byte (or seven address bits in early mode) |
| rx_valid | output | 1 | One-cycle strobe marking rx_data |
| scl_drive_low | output | 1 | 1 = pull the SCL line low |
| sda_drive_low | output | 1 | 1 = pull the SDA line low |

## Verification
The assertions take start_det to be a one-cycle pulse and treat SCL as open drain. The line is taken to be the wired AND of the remote master and scl_drive_low, so a held clock gives no edges. The assertions also assume hold_en and ack_en change only between clock edges and never together with start_det.

The bench models the wired-AND lines directly. Its master raises SCL and then waits for the line to actually go high. It keeps each SCL phase longer than the synchronizer latency and changes the control inputs only on falling clock edges. It walks every first-byte value, with the hold on or off and the decision varied, and adds mid-byte restarts.

// File: rtl/i2c_addr_hold_pkg.sv
package i2c_addr_hold_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_DATA,
      PH_WAIT9,
      PH_HOLD,
      PH_SETUP,
      PH_ACK,
      PH_ACK_HI
   } phase_t;

endpackage

// File: rtl/ahold_edge.sv
module ahold_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_rise,
   output logic scl_fall,
   output logic sda_s
);

   logic scl_s;
   logic scl_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= 2'b11;
            end else begin
               for (int i = SYNC_STAGES-1; i > 0; i--) chain[i] <= chain[i-1];
               chain[0] <= {scl_in, sda_in};
            end
         end
         assign scl_s = chain[SYNC_STAGES-1][1];
         assign sda_s = chain[SYNC_STAGES-1][0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_s;
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/ahold_shift.sv
module ahold_shift #(
   parameter int DATA_W        = 8,
   parameter int EARLY_CAPTURE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic              fall_tick,
   input  logic              sda_s,
   output logic              byte_done,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-2:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              cap_evt;
   logic [DATA_W-1:0] cap_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (clear) begin
         sh  <= '0;
         cnt <= '0;
      end else if (take) begin
         sh  <= {sh[DATA_W-3:0], sda_s};
         cnt <= cnt + 1'b1;
      end
   end

   assign byte_done = take && (cnt == LAST);
   assign cap_evt   = (EARLY_CAPTURE != 0) ? (fall_tick && (cnt == LAST)) : byte_done;

   generate
      if (EARLY_CAPTURE != 0) begin : g_early
         assign cap_val = {1'b0, sh};
      end else begin : g_full
         assign cap_val = {sh, sda_s};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= cap_evt && !clear;
         if (cap_evt && !clear) rx_data <= cap_val;
      end
   end

endmodule

// File: rtl/ahold_ctrl.sv
module ahold_ctrl
   import i2c_addr_hold_pkg::*;
#(
   parameter int ACK_SETUP = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_det,
   input  logic   scl_rise,
   input  logic   scl_fall,
   input  logic   byte_done,
   input  logic   hold_en,
   input  logic   ack_en,
   output phase_t phase,
   output logic   scl_low,
   output logic   sda_low
);

   localparam int TMR_W = $clog2(ACK_SETUP + 1);
   localparam logic [TMR_W-1:0] TMR_END = TMR_W'(ACK_SETUP - 1);

   logic [TMR_W-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
         tmr     <= '0;
      end else if (start_det) begin
         phase   <= PH_DATA;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
         tmr     <= '0;
      end else begin
         case (phase)
            PH_DATA: begin
               if (byte_done) phase <= PH_WAIT9;
            end
            PH_WAIT9: begin
               if (scl_fall) begin
                  if (hold_en) begin
                     phase   <= PH_HOLD;
                     scl_low <= 1'b1;
                  end else begin
                     phase   <= PH_ACK;
                     sda_low <= ack_en;
                  end
               end
            end
            PH_HOLD: begin
               if (!hold_en) begin
                  phase   <= PH_SETUP;
                  sda_low <= ack_en;
                  tmr     <= '0;
               end
            end
            PH_SETUP: begin
               if (tmr == TMR_END) begin
                  phase   <= PH_ACK;
                  scl_low <= 1'b0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            PH_ACK: begin
               if (scl_rise) phase <= PH_ACK_HI;
            end
            PH_ACK_HI: begin
               if (scl_fall) begin
                  phase   <= PH_IDLE;
                  sda_low <= 1'b0;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_addr_hold.sv
module i2c_addr_hold
   import i2c_addr_hold_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int ACK_SETUP     = 4,
   parameter int EARLY_CAPTURE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   input  logic              start_det,
   input  logic              hold_en,
   input  logic              ack_en,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              scl_drive_low,
   output logic              sda_drive_low
);

   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("i2c_addr_hold: DATA_W must be at least 3");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("i2c_addr_hold: SYNC_STAGES must be 0..4");
      end
      if (ACK_SETUP < 1) begin : g_bad_setup
         $error("i2c_addr_hold: ACK_SETUP must be at least 1");
      end
      if (EARLY_CAPTURE != 0 && EARLY_CAPTURE != 1) begin : g_bad_mode
         $error("i2c_addr_hold: EARLY_CAPTURE must be 0 or 1");
      end
   endgenerate

   logic   scl_rise;
   logic   scl_fall;
   logic   sda_s;
   logic   byte_done;
   phase_t phase;
   logic   in_data;

   ahold_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .sda_s    (sda_s)
   );

   assign in_data = (phase == PH_DATA);

   ahold_shift #(
      .DATA_W        (DATA_W),
      .EARLY_CAPTURE (EARLY_CAPTURE)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_det),
      .take      (scl_rise && in_data && !start_det),
      .fall_tick (scl_fall && in_data),
      .sda_s     (sda_s),
      .byte_done (byte_done),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid)
   );

   ahold_ctrl #(
      .ACK_SETUP (ACK_SETUP)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_det (start_det),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .byte_done (byte_done),
      .hold_en   (hold_en),
      .ack_en    (ack_en),
      .phase     (phase),
      .scl_low   (scl_drive_low),
      .sda_low   (sda_drive_low)
   );

endmodule

// File: rtl/i2c_addr_hold_chk.sv
module i2c_addr_hold_chk (
   input logic clk,
   input logic rst_n,
   input logic start_det,
   input logic hold_en,
   input logic ack_en,
   input logic rx_valid,
   input logic scl_drive_low,
   input logic sda_drive_low
);

   // R3: strobe lasts one cycle
   a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R5: a stretch only begins when it was enabled
   a_r5_hold_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> $past(hold_en));

   // R6: stretch persists while the enable stays set
   a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_drive_low && hold_en && !start_det) |=> scl_drive_low);

   // R7: SDA level already settled when SCL is let go
   a_r7_sda_settled: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_drive_low) && !$past(start_det)) |-> $stable(sda_drive_low));

   // R8: acknowledge drive only follows a positive decision
   a_r8_ack_decided: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> $past(ack_en));

endmodule

bind i2c_addr_hold i2c_addr_hold_chk u_chk (.*);

// File: tb/i2c_addr_hold_tb.sv
`timescale 1ns/1ps
module i2c_addr_hold_tb;

   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_scl = 1'b1;
   logic master_sda = 1'b1;
   logic start_det = 1'b0;
   logic hold_en = 1'b0;
   logic ack_en = 1'b0;

   logic [7:0] rx_data, e_data;
   logic rx_valid, e_valid;
   logic scl_drive_low, sda_drive_low, e_scl, e_sda;
   logic scl_line, sda_line;

   int total = 0;
   int bad = 0;
   int v_cnt = 0, e_cnt = 0;
   logic [7:0] v_data = '0, e_last = '0;
   bit hold_seen = 0;
   bit done = 0;

   always #2 clk = ~clk;

   assign scl_line = master_scl & ~scl_drive_low;
   assign sda_line = master_sda & ~sda_drive_low;

   i2c_addr_hold u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
      .start_det(start_det), .hold_en(hold_en), .ack_en(ack_en),
      .rx_data(rx_data), .rx_valid(rx_valid),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low));

   i2c_addr_hold #(.EARLY_CAPTURE(1)) u_dut_early (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
      .start_det(start_det), .hold_en(1'b0), .ack_en(1'b0),
      .rx_data(e_data), .rx_valid(e_valid),
      .scl_drive_low(e_scl), .sda_drive_low(e_sda));

   always @(negedge clk) begin
      if (rx_valid) begin v_cnt++; v_data = rx_data; end
      if (e_valid) begin e_cnt++; e_last = e_data; end
      if (scl_drive_low) hold_seen = 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      @(negedge clk);
      while (!scl_line) @(negedge clk);
   endtask

   task automatic do_start();
      master_sda = 1'b1;
      wait_cyc(HALF);
      master_scl = 1'b1;
      wait_cyc(HALF);
      start_det = 1'b1;
      @(negedge clk);
      start_det = 1'b0;
      master_sda = 1'b0;
      wait_cyc(HALF);
      master_scl = 1'b0;
      wait_cyc(HALF);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         master_sda = b[i];
         wait_cyc(HALF);
         master_scl = 1'b1;
         wait_scl_high();
         wait_cyc(HALF);
         master_scl = 1'b0;
         wait_cyc(HALF);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input bit hen, input bit ack, input bit first);
      hold_en = hen;
      ack_en = ack;
      v_cnt = 0; e_cnt = 0; hold_seen = 0;
      send_bits(b, 8);
      master_sda = 1'b1;
      wait_cyc(HALF);
      if (first) begin
         check(v_cnt == 1, "R3 one strobe", v_cnt, 1);
         check(v_data == b, "R2 byte", v_data, b);
         check(e_cnt == 1 && e_last == {1'b0, b[7:1]}, "R4 early data", e_last, {1'b0, b[7:1]});
      end else begin
         check(v_cnt == 0, "R3 no strobe on later byte", v_cnt, 0);
      end
      if (first && hen) begin
         check(scl_drive_low == 1'b1, "R5 hold asserted", scl_drive_low, 1);
         master_scl = 1'b1;
         wait_cyc(60);
         check(scl_line == 1'b0 && scl_drive_low, "R6 hold kept", scl_line, 0);
         hold_en = 1'b0;
         wait_cyc(2);
         check(sda_drive_low == ack && scl_drive_low, "R7 ack before release", sda_drive_low, ack);
         wait_scl_high();
         check(sda_line == !ack, "R7 sda at release", sda_line, !ack);
      end else begin
         check(hold_seen == 0, "R8 no stretch", hold_seen, 0);
         check(sda_drive_low == (first & ack), "R8 ack at fall", sda_drive_low, first & ack);
         master_scl = 1'b1;
         wait_scl_high();
      end
      wait_cyc(HALF);
      check(sda_line == !(first & ack), "R9 ack in 9th high", sda_line, !(first & ack));
      master_scl = 1'b0;
      wait_cyc(HALF);
      check(sda_drive_low == 1'b0 && scl_drive_low == 1'b0, "R9 drive removed", sda_drive_low, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      check(!rx_valid && !scl_drive_low && !sda_drive_low, "R1 in reset", scl_drive_low, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      check(!rx_valid && !scl_drive_low && !sda_drive_low, "R1 after reset", sda_drive_low, 0);

      for (int b = 0; b < 256; b++) begin
         do_start();
         send_byte(8'(b), b[0] ^ b[3], b[1], 1'b1);
         if ((b % 16) == 0) send_byte(8'(~b), 1'b1, 1'b1, 1'b0);
      end

      // R10: restart inside a byte
      for (int n = 1; n < 8; n++) begin
         do_start();
         v_cnt = 0;
         send_bits(8'hFF, n);
         check(v_cnt == 0, "R10 partial no strobe", v_cnt, 0);
         do_start();
         send_byte(8'h5A ^ 8'(n), n[0], 1'b1, 1'b1);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule